// File: doc/BRIEF.md
# DRAM Bank Open-Row Tracker

This block follows which row is latched in each bank of every device on a packet DRAM channel. It takes one access at a time, given as device, bank, row and column, and sorts it into one of three cases. A row hit finds the wanted row already open. A closed-bank miss finds the bank idle. A row conflict finds another row open in that bank. It then issues, one per cycle, the commands the access needs, ending with the column command.

The channel holds several devices, each with its own banks. Only a limited number of banks per device may be open at a time, and that limit is lower than the bank count. When a miss would break the limit, the block closes the least recently used open bank of that device first. It reports that bank as the victim.

A level close-all input stands in for refresh and closes every bank on every device. The tracker keeps only ordering. Command timing, refresh scheduling and data movement belong to the controller around it.

Top module: `dram_row_tracker`

## Requirements
- R1: An access to an open bank whose latched row equals the requested row is classed as a hit (acc_class 0) and produces a single column command.
- R2: An access to a closed bank, when the device has fewer than MAX_OPEN banks open, is classed as a miss (acc_class 1) and produces an activate command followed by a column command.
- R3: An access to an open bank that holds a different row is classed as a conflict (acc_class 2) and produces a precharge of that same bank, then an activate, then a column command.
- R4: A miss on a device that already has MAX_OPEN banks open raises victim_valid. It precharges the least recently used open bank of that device (reported on victim_bank) before the activate and the column command. The number of open banks per device never exceeds MAX_OPEN.
- R5: Each device's open banks, latched rows and usage order are tracked independently of every other device.
- R6: Commands are presented one per cycle on cmd_valid/cmd_ready, with cmd_kind 1 for precharge, 2 for activate and 3 for column. While cmd_valid is high and cmd_ready is low, the command fields hold steady.
- R7: req_ready is high only when no command sequence is pending and close_all is low. acc_class, victim_valid and victim_bank hold for the whole sequence of one access.
- R8: A close_all seen while no sequence is pending closes every bank on every device. It takes precedence over a request presented in the same cycle, which is accepted only after close_all drops.
- R9: Reset closes all banks and clears the per-device open counts. After reset, req_ready is 1 and cmd_valid is 0.
- R10: The activate command carries the requested row on cmd_row. The column command carries the requested device, bank and column on cmd_dev, cmd_bank and cmd_col.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Tracker can accept an access |
| req_dev | input | DEV_W | Device index of the access |
| req_bank | input | BANK_W | Bank index within the device |
| req_row | input | ROW_W | Row to access |
| req_col | input | COL_W | Column unit within the row |
| close_all | input | 1 | Close every bank (refresh stand-in) |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command taken downstream |
| cmd_kind | output | 2 | 1 precharge, 2 activate, 3 column |
| cmd_dev | output | DEV_W | Device the command addresses |
| cmd_bank | output | BANK_W | Bank the command addresses |
| cmd_row | output | ROW_W | Row for activate and column commands |
| cmd_col | output | COL_W | Column unit for the column command |
| acc_class | output | 2 | 0 hit, 1 miss, 2 conflict |
| victim_valid | output | 1 | A victim bank is being closed for this access |
| victim_bank | output | BANK_W | Bank chosen for closing |

## Verification
Close-all and a new request can land in the same cycle. The bench provokes this by raising both together while the requested bank is open with a matching row, so the access would be a hit if it got in first. It judges the outcome in two steps. First, no command may appear while close_all is held. Then, once close_all drops, the same request must come out as a miss with no victim. A further access on another device then shows that the clearing reached every device and not just the one that was requested.

// File: rtl/drt_pkg.sv
package drt_pkg;

   typedef enum logic [1:0] {
      CLS_HIT      = 2'd0,
      CLS_MISS     = 2'd1,
      CLS_CONFLICT = 2'd2
   } drt_cls_e;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_PRE  = 2'd1,
      CMD_ACT  = 2'd2,
      CMD_COL  = 2'd3
   } drt_cmd_e;

endpackage

// File: rtl/drt_bank_table.sv
module drt_bank_table #(
   parameter int NUM_DEV     = 8,
   parameter int NUM_BANK    = 16,
   parameter int MAX_OPEN    = 8,
   parameter int ROW_W       = 10,
   parameter bit VICTIM_LRU  = 1'b1,
   localparam int DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int BANK_W     = $clog2(NUM_BANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DEV_W-1:0]  lk_dev,
   input  logic [BANK_W-1:0] lk_bank,
   input  logic [ROW_W-1:0]  lk_row,
   output logic              lk_open,
   output logic              lk_match,
   output logic              lk_full,
   output logic [BANK_W-1:0] lk_victim,
   input  logic              upd_en,
   input  logic [DEV_W-1:0]  upd_dev,
   input  logic [BANK_W-1:0] upd_bank,
   input  logic [ROW_W-1:0]  upd_row,
   input  logic              vic_en,
   input  logic [BANK_W-1:0] vic_bank,
   input  logic              clr_all
);

   localparam int CNT_W = $clog2(NUM_BANK + 1);

   logic [NUM_DEV-1:0] dv_open;
   logic [NUM_DEV-1:0] dv_match;
   logic [NUM_DEV-1:0] dv_full;
   logic [BANK_W-1:0]  dv_vic [NUM_DEV];

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic [NUM_BANK-1:0] open_r;
      logic [ROW_W-1:0]    row_r [NUM_BANK];
      logic [CNT_W-1:0]    cnt;
      logic                sel;

      assign sel = upd_en && (upd_dev == DEV_W'(d));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_r <= '0;
            for (int j = 0; j < NUM_BANK; j++) row_r[j] <= '0;
         end else if (clr_all) begin
            open_r <= '0;
         end else if (sel) begin
            if (vic_en) open_r[vic_bank] <= 1'b0;
            open_r[upd_bank] <= 1'b1;
            row_r[upd_bank]  <= upd_row;
         end
      end

      always_comb begin
         cnt = '0;
         for (int j = 0; j < NUM_BANK; j++) cnt = cnt + CNT_W'(open_r[j]);
      end

      assign dv_open[d]  = open_r[lk_bank];
      assign dv_match[d] = (row_r[lk_bank] == lk_row);
      assign dv_full[d]  = (cnt >= CNT_W'(MAX_OPEN));

      if (VICTIM_LRU) begin : g_lru
         // rank 0 = most recently used; ranks form a permutation per device
         logic [BANK_W-1:0] rank_r [NUM_BANK];
         logic [BANK_W-1:0] best;
         logic [BANK_W-1:0] best_rank;
         logic              found;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int j = 0; j < NUM_BANK; j++) rank_r[j] <= BANK_W'(j);
            end else if (sel && !clr_all) begin
               for (int j = 0; j < NUM_BANK; j++) begin
                  if (BANK_W'(j) == upd_bank) rank_r[j] <= '0;
                  else if (rank_r[j] < rank_r[upd_bank]) rank_r[j] <= rank_r[j] + 1'b1;
               end
            end
         end

         always_comb begin
            best      = '0;
            best_rank = '0;
            found     = 1'b0;
            for (int j = 0; j < NUM_BANK; j++) begin
               if (open_r[j] && (!found || rank_r[j] > best_rank)) begin
                  best      = BANK_W'(j);
                  best_rank = rank_r[j];
                  found     = 1'b1;
               end
            end
         end
         assign dv_vic[d] = best;
      end else begin : g_low
         logic [BANK_W-1:0] best;
         always_comb begin
            best = '0;
            for (int j = NUM_BANK - 1; j >= 0; j--) begin
               if (open_r[j]) best = BANK_W'(j);
            end
         end
         assign dv_vic[d] = best;
      end

      // R4
      open_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(open_r) <= MAX_OPEN);

      // R8
      clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr_all |=> (open_r == '0));
   end

   assign lk_open   = dv_open[lk_dev];
   assign lk_match  = dv_match[lk_dev];
   assign lk_full   = dv_full[lk_dev];
   assign lk_victim = dv_vic[lk_dev];

endmodule

// File: rtl/drt_cmd_seq.sv
module drt_cmd_seq
   import drt_pkg::*;
#(
   parameter int DEV_W  = 3,
   parameter int BANK_W = 4,
   parameter int ROW_W  = 10,
   parameter int COL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              close_all,
   input  logic              lk_open,
   input  logic              lk_match,
   input  logic              lk_full,
   input  logic [BANK_W-1:0] lk_victim,
   output logic              upd_en,
   output logic              vic_en,
   output logic              clr_all,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [DEV_W-1:0]  cmd_dev,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [1:0]        acc_class,
   output logic              victim_valid,
   output logic [BANK_W-1:0] victim_bank
);

   drt_cmd_e          state_q;
   drt_cls_e          cls_q, cls_d;
   logic [DEV_W-1:0]  dev_q;
   logic [BANK_W-1:0] bank_q, pre_bank_q;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   logic              vic_q;
   logic              idle, accept;

   assign idle      = (state_q == CMD_NONE);
   assign req_ready = idle && !close_all;
   assign accept    = req_valid && req_ready;
   assign clr_all   = idle && close_all;
   assign upd_en    = accept;

   always_comb begin
      if (!lk_open)      cls_d = CLS_MISS;
      else if (lk_match) cls_d = CLS_HIT;
      else               cls_d = CLS_CONFLICT;
   end

   assign vic_en = accept && (cls_d == CLS_MISS) && lk_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= CMD_NONE;
         cls_q      <= CLS_HIT;
         dev_q      <= '0;
         bank_q     <= '0;
         pre_bank_q <= '0;
         row_q      <= '0;
         col_q      <= '0;
         vic_q      <= 1'b0;
      end else if (accept) begin
         cls_q      <= cls_d;
         dev_q      <= req_dev;
         bank_q     <= req_bank;
         row_q      <= req_row;
         col_q      <= req_col;
         vic_q      <= vic_en;
         pre_bank_q <= vic_en ? lk_victim : req_bank;
         if (cls_d == CLS_CONFLICT || vic_en) state_q <= CMD_PRE;
         else if (cls_d == CLS_MISS)          state_q <= CMD_ACT;
         else                                 state_q <= CMD_COL;
      end else if (cmd_valid && cmd_ready) begin
         case (state_q)
            CMD_PRE: state_q <= CMD_ACT;
            CMD_ACT: state_q <= CMD_COL;
            default: state_q <= CMD_NONE;
         endcase
      end
   end

   assign cmd_valid    = !idle;
   assign cmd_kind     = state_q;
   assign cmd_dev      = dev_q;
   assign cmd_bank     = (state_q == CMD_PRE) ? pre_bank_q : bank_q;
   assign cmd_row      = row_q;
   assign cmd_col      = col_q;
   assign acc_class    = cls_q;
   assign victim_valid = vic_q && !idle;
   assign victim_bank  = vic_q ? pre_bank_q : '0;

   // R6
   pre_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_kind == CMD_PRE) |=> (cmd_valid && cmd_kind == CMD_ACT));

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_bank)
                                     && $stable(cmd_row)));

   // R7
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && cmd_valid));

   // R7
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> cmd_valid);

   // R1
   hit_col_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cmd_valid) && acc_class == CLS_HIT) |-> (cmd_kind == CMD_COL));

   // R7
   class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && $past(cmd_valid) && !$past(req_valid && req_ready))
         |-> ($stable(acc_class) && $stable(victim_bank)));

endmodule

// File: rtl/dram_row_tracker.sv
module dram_row_tracker #(
   parameter int NUM_DEV    = 8,
   parameter int NUM_BANK   = 16,
   parameter int MAX_OPEN   = 8,
   parameter int ROW_W      = 10,
   parameter int COL_W      = 6,
   parameter bit VICTIM_LRU = 1'b1,
   localparam int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int BANK_W    = $clog2(NUM_BANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic              close_all,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [1:0]        cmd_kind,
   output logic [DEV_W-1:0]  cmd_dev,
   output logic [BANK_W-1:0] cmd_bank,
   output logic [ROW_W-1:0]  cmd_row,
   output logic [COL_W-1:0]  cmd_col,
   output logic [1:0]        acc_class,
   output logic              victim_valid,
   output logic [BANK_W-1:0] victim_bank
);

   if (NUM_BANK < 2 || (1 << BANK_W) != NUM_BANK) begin : g_bad_bank
      $error("NUM_BANK must be a power of two, at least 2");
   end
   if (MAX_OPEN < 1 || MAX_OPEN > NUM_BANK) begin : g_bad_cap
      $error("MAX_OPEN must lie between 1 and NUM_BANK");
   end
   if (NUM_DEV < 1 || ROW_W < 1 || COL_W < 1) begin : g_bad_width
      $error("device count and field widths must be positive");
   end

   logic              lk_open, lk_match, lk_full;
   logic [BANK_W-1:0] lk_victim;
   logic              upd_en, vic_en, clr_all;

   drt_bank_table #(
      .NUM_DEV    (NUM_DEV),
      .NUM_BANK   (NUM_BANK),
      .MAX_OPEN   (MAX_OPEN),
      .ROW_W      (ROW_W),
      .VICTIM_LRU (VICTIM_LRU)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_dev    (req_dev),
      .lk_bank   (req_bank),
      .lk_row    (req_row),
      .lk_open   (lk_open),
      .lk_match  (lk_match),
      .lk_full   (lk_full),
      .lk_victim (lk_victim),
      .upd_en    (upd_en),
      .upd_dev   (req_dev),
      .upd_bank  (req_bank),
      .upd_row   (req_row),
      .vic_en    (vic_en),
      .vic_bank  (lk_victim),
      .clr_all   (clr_all)
   );

   drt_cmd_seq #(
      .DEV_W  (DEV_W),
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_dev      (req_dev),
      .req_bank     (req_bank),
      .req_row      (req_row),
      .req_col      (req_col),
      .close_all    (close_all),
      .lk_open      (lk_open),
      .lk_match     (lk_match),
      .lk_full      (lk_full),
      .lk_victim    (lk_victim),
      .upd_en       (upd_en),
      .vic_en       (vic_en),
      .clr_all      (clr_all),
      .cmd_valid    (cmd_valid),
      .cmd_ready    (cmd_ready),
      .cmd_kind     (cmd_kind),
      .cmd_dev      (cmd_dev),
      .cmd_bank     (cmd_bank),
      .cmd_row      (cmd_row),
      .cmd_col      (cmd_col),
      .acc_class    (acc_class),
      .victim_valid (victim_valid),
      .victim_bank  (victim_bank)
   );

endmodule

// File: tb/dram_row_tracker_test.sv
`timescale 1ns/100ps
module dram_row_tracker_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [2:0] req_dev = '0;
   logic [3:0] req_bank = '0;
   logic [9:0] req_row = '0;
   logic [5:0] req_col = '0;
   logic       close_all = 1'b0;
   logic       cmd_valid;
   logic       cmd_ready = 1'b1;
   logic [1:0] cmd_kind;
   logic [2:0] cmd_dev;
   logic [3:0] cmd_bank;
   logic [9:0] cmd_row;
   logic [5:0] cmd_col;
   logic [1:0] acc_class;
   logic       victim_valid;
   logic [3:0] victim_bank;

   always #2.5 clk = ~clk;

   dram_row_tracker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_dev(req_dev), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .close_all(close_all), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
      .cmd_col(cmd_col), .acc_class(acc_class), .victim_valid(victim_valid),
      .victim_bank(victim_bank)
   );

   typedef struct packed {
      logic [2:0] dev;
      logic [3:0] bank;
      logic [9:0] row;
      logic [1:0] cls;
      logic       vic;
      logic [3:0] vbank;
   } vec_t;

   // cls: 0 hit, 1 miss, 2 conflict
   localparam vec_t VECS [16] = '{
      '{3'd0, 4'd0, 10'd5, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd0, 10'd5, 2'd0, 1'b0, 4'd0},
      '{3'd0, 4'd0, 10'd7, 2'd2, 1'b0, 4'd0},
      '{3'd1, 4'd0, 10'd5, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd1, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd2, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd3, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd4, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd5, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd6, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd7, 10'd1, 2'd1, 1'b0, 4'd0},
      '{3'd0, 4'd0, 10'd7, 2'd0, 1'b0, 4'd0},
      '{3'd0, 4'd8, 10'd3, 2'd1, 1'b1, 4'd1},
      '{3'd0, 4'd1, 10'd1, 2'd1, 1'b1, 4'd2},
      '{3'd0, 4'd2, 10'd1, 2'd1, 1'b1, 4'd3},
      '{3'd1, 4'd0, 10'd6, 2'd2, 1'b0, 4'd0}
   };

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   int         got_n;
   logic [1:0] got_kind [4];
   logic [3:0] got_bank [4];
   logic [2:0] got_dev;
   logic [9:0] got_row;
   logic [5:0] got_col;
   logic [1:0] got_cls;
   logic       got_vic;
   logic [3:0] got_vbank;

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic collect(input int stall);
      got_n = 0;
      while (cmd_valid && got_n < 4) begin
         got_kind[got_n] = cmd_kind;
         got_bank[got_n] = cmd_bank;
         got_cls   = acc_class;
         got_vic   = victim_valid;
         got_vbank = victim_bank;
         if (cmd_kind == 2'd2) got_row = cmd_row;
         if (cmd_kind == 2'd3) begin
            got_col = cmd_col;
            got_dev = cmd_dev;
         end
         if (got_n == 0 && stall > 0) begin
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               chk("R6 held kind during stall", int'(cmd_kind), int'(got_kind[0]));
               chk("R6 held bank during stall", int'(cmd_bank), int'(got_bank[0]));
            end
            cmd_ready = 1'b1;
         end
         got_n++;
         @(negedge clk);
      end
   endtask

   task automatic send(input logic [2:0] d, input logic [3:0] b, input logic [9:0] r,
                       input logic [5:0] c, input int stall);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      if (stall > 0) cmd_ready = 1'b0;
      req_dev = d; req_bank = b; req_row = r; req_col = c;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      collect(stall);
   endtask

   task automatic check_result(input string tag, input logic [3:0] b, input logic [9:0] r,
                               input logic [5:0] c, input logic [2:0] d,
                               input logic [1:0] cls, input logic vic, input logic [3:0] vb);
      int nexp;
      int k0;
      nexp = (cls == 2'd0) ? 1 : ((cls == 2'd2 || vic) ? 3 : 2);
      chk({tag, " R1 R2 R3 class"}, int'(got_cls), int'(cls));
      chk({tag, " R6 command count"}, got_n, nexp);
      k0 = 4 - nexp;
      for (int i = 0; i < nexp && i < got_n; i++)
         chk({tag, " R6 command order"}, int'(got_kind[i]), k0 + i);
      chk({tag, " R4 victim_valid"}, int'(got_vic), int'(vic));
      if (vic) chk({tag, " R4 victim bank"}, int'(got_vbank), int'(vb));
      if (nexp == 3) chk({tag, " R3 R4 precharge bank"}, int'(got_bank[0]),
                         int'(vic ? vb : b));
      if (nexp >= 2) chk({tag, " R10 activate row"}, int'(got_row), int'(r));
      if (got_n == nexp) begin
         chk({tag, " R10 column bank"}, int'(got_bank[nexp-1]), int'(b));
         chk({tag, " R10 column value"}, int'(got_col), int'(c));
         chk({tag, " R5 column device"}, int'(got_dev), int'(d));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 req_ready in reset", int'(req_ready), 1);
      chk("R9 cmd_valid in reset", int'(cmd_valid), 0);
      rst_n = 1'b1;

      for (int i = 0; i < 16; i++) begin
         send(VECS[i].dev, VECS[i].bank, VECS[i].row, 6'(i + 10), 0);
         check_result($sformatf("vec%0d", i), VECS[i].bank, VECS[i].row, 6'(i + 10),
                      VECS[i].dev, VECS[i].cls, VECS[i].vic, VECS[i].vbank);
      end

      // R6 backpressure on a conflict (d1 b0 holds row 6)
      send(3'd1, 4'd0, 10'd9, 6'd33, 3);
      check_result("stall", 4'd0, 10'd9, 6'd33, 3'd1, 2'd2, 1'b0, 4'd0);

      // R8 close_all and a would-be hit arrive together (d0 b0 holds row 7)
      @(negedge clk);
      close_all = 1'b1;
      req_dev = 3'd0; req_bank = 4'd0; req_row = 10'd7; req_col = 6'd40;
      req_valid = 1'b1;
      @(negedge clk);
      chk("R8 no command while close_all", int'(cmd_valid), 0);
      chk("R7 req_ready low under close_all", int'(req_ready), 0);
      close_all = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      collect(0);
      check_result("after_close", 4'd0, 10'd7, 6'd40, 3'd0, 2'd1, 1'b0, 4'd0);
      // R8 other device was cleared too
      send(3'd1, 4'd0, 10'd9, 6'd41, 0);
      check_result("close_other_dev", 4'd0, 10'd9, 6'd41, 3'd1, 2'd1, 1'b0, 4'd0);
      send(3'd0, 4'd9, 10'd1, 6'd42, 0);
      check_result("close_count", 4'd9, 10'd1, 6'd42, 3'd0, 2'd1, 1'b0, 4'd0);

      // R9 reset clears open banks
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R9 req_ready after reset", int'(req_ready), 1);
      chk("R9 cmd_valid after reset", int'(cmd_valid), 0);
      send(3'd0, 4'd9, 10'd1, 6'd43, 0);
      check_result("after_reset", 4'd9, 10'd1, 6'd43, 3'd0, 2'd1, 1'b0, 4'd0);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule